// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block is an 18-bit first-in first-out buffer whose write side and read side each run on their own clock. The two clocks may be unrelated or may be one and the same net. Each side keeps its own binary pointer. A Gray-coded copy of that pointer crosses to the other side through a chain of flip-flops. Every flag is computed from local state only, so the block may report full or empty later than the true level, but it never overruns or underruns its storage.

A mode pin is captured while reset is high and picks one of two read behaviours. In standard timing, a read request loads the next stored word into the output register. In fall-through timing, the oldest word moves to the output on its own. In that mode the empty flag means "output ready" and the full flag means "input ready". Besides full and empty, the block gives a half-full flag and two threshold flags, near-full and near-empty. Both thresholds are programmable through a load strobe on the write port, and both have defaults that reset restores. An output-enable input gates the read data bus and reports whether the bus is driven.

Top module: `dual_clock_fifo`

## Requirements
- R1: While reset is high and right after it is released, the empty flag is 1 (standard mode), full is 0, half-full is 0, near-empty is 1 and near-full is 0.
- R2: In standard mode, each read request on a non-empty FIFO places the oldest unread word on rdata on the read-clock edge that samples the request. Words leave in the order they were written.
- R3: After DEPTH stored words, full is 1. A write attempted while full is dropped and the write pointer does not move.
- R4: A read request while the FIFO is empty is dropped. The read pointer and rdata are unchanged, so the next written word is the next one read.
- R5: With FLAG_STAGES=1 and one clock shared by both ports, the empty flag is still 1 one edge after the write edge and drops to 0 on the second edge.
- R6: In fall-through mode (rd_mode=1 during reset), the first written word shows on rdata with empty_or=1 and no read request. A read request consumes that word, and empty_or returns to 0 once nothing is left. full_ir is 1 while there is space.
- R7: half_full is 1 exactly when more than DEPTH/2 words are stored.
- R8: almost_full is 1 when the stored count is at least DEPTH minus the near-full offset. almost_empty is 1 when the count is at most the near-empty offset. Both offsets reset to 63 for DEPTH=256 and to 127 for larger depths.
- R9: With ld=1, each accepted write strobe stores wdata[AW-1:0] as an offset rather than as data: first the near-empty offset, then the near-full offset, alternating after that.
- R10: With oe=0, rdata reads all zeros and rdata_drv is 0. With oe=1, rdata_drv is 1 and the held output word returns.
- R11: Each Gray-coded pointer changes by at most one bit on any edge of its own clock.
- R12: rd_mode is captured only while reset is high. Changing it afterwards leaves standard behaviour in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rst | input | 1 | Synchronous active-high reset, held across edges of both clocks |
| rd_mode | input | 1 | Read timing captured at reset: 0 standard, 1 fall-through |
| wen | input | 1 | Write strobe |
| ld | input | 1 | With wen, routes wdata to the offset registers |
| wdata | input | 18 | Write data or offset value |
| rclk | input | 1 | Read-side clock |
| ren | input | 1 | Read request |
| oe | input | 1 | Output enable for rdata |
| rdata | output | 18 | Output data register, zero when oe is low |
| rdata_drv | output | 1 | High when rdata is driven |
| full_ir | output | 1 | Full in standard mode, input-ready in fall-through mode |
| empty_or | output | 1 | Empty in standard mode, output-ready in fall-through mode |
| half_full | output | 1 | More than half the depth is in use |
| almost_full | output | 1 | Level at or above the near-full threshold |
| almost_empty | output | 1 | Level at or below the near-empty threshold |

## Verification
The bench builds the block with DEPTH=256, FLAG_STAGES=1 and ALMOST_REG=1, and ties both clock inputs to one net. The small depth lets the bench fill the whole buffer in a few hundred cycles. That puts the full, half-full and both threshold boundaries within reach, each tested one word either side of its edge. Because the clocks are coincident, the two-flop crossing delay becomes an exact edge count that the bench can pin down. Both read modes are reached by re-running reset with a different mode pin.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  localparam int DATA_W = 18;

  typedef enum logic {
    RD_STD  = 1'b0,
    RD_FWFT = 1'b1
  } rd_mode_e;

  function automatic int def_offset(input int depth);
    return (depth <= 256) ? 63 : 127;
  endfunction
endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int W      = 9,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) pipe[0] <= '0;
    else     pipe[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) pipe[s] <= '0;
      else     pipe[s] <= pipe[s-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/dcf_ram.sv
module dcf_ram #(
  parameter int DW = 18,
  parameter int AW = 8
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [1 << AW];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/dcf_wr_ctl.sv
module dcf_wr_ctl
  import dcf_pkg::*;
#(
  parameter  int DEPTH      = 256,
  parameter  int STAGES     = 2,
  parameter  bit ALMOST_REG = 1'b1,
  localparam int AW         = $clog2(DEPTH),
  localparam int PW         = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_in,
  input  logic          wen,
  input  logic          ld,
  input  logic [AW-1:0] off_in,
  input  logic [PW-1:0] rgray_x,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [PW-1:0] wgray,
  output logic          full,
  output logic          fwft,
  output logic          half,
  output logic          almost_full,
  output logic [AW-1:0] ae_off
);
  localparam logic [AW-1:0] DEF_OFF = AW'(def_offset(DEPTH));

  logic [PW-1:0] rq, rbin, wbin, wbin_nxt, level;
  logic [AW-1:0] af_off;
  logic          off_sel;
  logic          half_c, af_c;

  dcf_sync #(.W(PW), .STAGES(STAGES)) u_rsync (
    .clk(clk), .rst(rst), .d(rgray_x), .q(rq)
  );

  always_comb begin
    rbin[PW-1] = rq[PW-1];
    for (int i = PW - 2; i >= 0; i--) rbin[i] = rbin[i+1] ^ rq[i];
  end

  assign level    = wbin - rbin;
  assign full     = (level == PW'(DEPTH));
  assign we       = wen && !ld && !full;
  assign waddr    = wbin[AW-1:0];
  assign wbin_nxt = wbin + 1'b1;
  assign half_c   = level > PW'(DEPTH / 2);
  assign af_c     = level >= (PW'(DEPTH) - PW'(af_off));

  always_ff @(posedge clk) begin
    if (rst) begin
      wbin    <= '0;
      wgray   <= '0;
      fwft    <= (rd_mode_e'(mode_in) == RD_FWFT);
      ae_off  <= DEF_OFF;
      af_off  <= DEF_OFF;
      off_sel <= 1'b0;
    end else begin
      if (we) begin
        wbin  <= wbin_nxt;
        wgray <= wbin_nxt ^ (wbin_nxt >> 1);
      end
      if (wen && ld) begin
        if (!off_sel) ae_off <= off_in;
        else          af_off <= off_in;
        off_sel <= ~off_sel;
      end
    end
  end

  if (ALMOST_REG) begin : g_reg_flags
    always_ff @(posedge clk) begin
      if (rst) begin
        half        <= 1'b0;
        almost_full <= 1'b0;
      end else begin
        half        <= half_c;
        almost_full <= af_c;
      end
    end
  end else begin : g_comb_flags
    assign half        = half_c;
    assign almost_full = af_c;
  end
endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl
  import dcf_pkg::*;
#(
  parameter  int DEPTH      = 256,
  parameter  int STAGES     = 2,
  parameter  bit ALMOST_REG = 1'b1,
  localparam int AW         = $clog2(DEPTH),
  localparam int PW         = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_in,
  input  logic          ren,
  input  logic [PW-1:0] wgray_x,
  input  logic [AW-1:0] ae_off,
  output logic          re,
  output logic [AW-1:0] raddr,
  output logic [PW-1:0] rgray,
  output logic          mem_empty,
  output logic          ovalid,
  output logic          fwft,
  output logic          almost_empty
);
  logic [PW-1:0] wq, wbin, rbin, rbin_nxt, mcount;
  logic [PW:0]   level;
  logic          ae_c;

  dcf_sync #(.W(PW), .STAGES(STAGES)) u_wsync (
    .clk(clk), .rst(rst), .d(wgray_x), .q(wq)
  );

  always_comb begin
    wbin[PW-1] = wq[PW-1];
    for (int i = PW - 2; i >= 0; i--) wbin[i] = wbin[i+1] ^ wq[i];
  end

  assign mcount    = wbin - rbin;
  assign mem_empty = (mcount == '0);
  assign re        = !mem_empty && (fwft ? (!ovalid || ren) : ren);
  assign raddr     = rbin[AW-1:0];
  assign rbin_nxt  = rbin + 1'b1;
  assign level     = {1'b0, mcount} + (PW+1)'(fwft && ovalid);
  assign ae_c      = level <= (PW+1)'(ae_off);

  always_ff @(posedge clk) begin
    if (rst) begin
      rbin   <= '0;
      rgray  <= '0;
      ovalid <= 1'b0;
      fwft   <= (rd_mode_e'(mode_in) == RD_FWFT);
    end else begin
      if (re) begin
        rbin   <= rbin_nxt;
        rgray  <= rbin_nxt ^ (rbin_nxt >> 1);
        ovalid <= 1'b1;
      end else if (ren) begin
        ovalid <= 1'b0;
      end
    end
  end

  if (ALMOST_REG) begin : g_reg_flag
    always_ff @(posedge clk) begin
      if (rst) almost_empty <= 1'b1;
      else     almost_empty <= ae_c;
    end
  end else begin : g_comb_flag
    assign almost_empty = ae_c;
  end
endmodule

// File: rtl/dual_clock_fifo.sv
module dual_clock_fifo
  import dcf_pkg::*;
#(
  parameter int DEPTH       = 256,
  parameter int FLAG_STAGES = 1,
  parameter bit ALMOST_REG  = 1'b1
) (
  input  logic              wclk,
  input  logic              rst,
  input  logic              rd_mode,
  input  logic              wen,
  input  logic              ld,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rclk,
  input  logic              ren,
  input  logic              oe,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_drv,
  output logic              full_ir,
  output logic              empty_or,
  output logic              half_full,
  output logic              almost_full,
  output logic              almost_empty
);
  localparam int AW     = $clog2(DEPTH);
  localparam int PW     = AW + 1;
  localparam int STAGES = FLAG_STAGES + 1;

  logic              we_w, full_w, fwft_w;
  logic [AW-1:0]     waddr_w, ae_off_w;
  logic [PW-1:0]     wgray_w, rgray_r;
  logic              re_r, mem_empty_r, ovalid_r, fwft_r;
  logic [AW-1:0]     raddr_r;
  logic [DATA_W-1:0] q_r;

  dcf_wr_ctl #(.DEPTH(DEPTH), .STAGES(STAGES), .ALMOST_REG(ALMOST_REG)) u_wr (
    .clk(wclk), .rst(rst), .mode_in(rd_mode), .wen(wen), .ld(ld),
    .off_in(wdata[AW-1:0]), .rgray_x(rgray_r), .we(we_w), .waddr(waddr_w),
    .wgray(wgray_w), .full(full_w), .fwft(fwft_w), .half(half_full),
    .almost_full(almost_full), .ae_off(ae_off_w)
  );

  dcf_rd_ctl #(.DEPTH(DEPTH), .STAGES(STAGES), .ALMOST_REG(ALMOST_REG)) u_rd (
    .clk(rclk), .rst(rst), .mode_in(rd_mode), .ren(ren), .wgray_x(wgray_w),
    .ae_off(ae_off_w), .re(re_r), .raddr(raddr_r), .rgray(rgray_r),
    .mem_empty(mem_empty_r), .ovalid(ovalid_r), .fwft(fwft_r),
    .almost_empty(almost_empty)
  );

  dcf_ram #(.DW(DATA_W), .AW(AW)) u_ram (
    .wclk(wclk), .we(we_w), .waddr(waddr_w), .wdata(wdata),
    .rclk(rclk), .re(re_r), .raddr(raddr_r), .rdata(q_r)
  );

  assign full_ir   = fwft_w ? !full_w : full_w;
  assign empty_or  = fwft_r ? ovalid_r : mem_empty_r;
  assign rdata     = oe ? q_r : '0;
  assign rdata_drv = oe;
endmodule

// File: rtl/dcf_chk.sv
module dcf_chk #(
  parameter int PW = 9
) (
  input logic          wclk,
  input logic          rclk,
  input logic          rst,
  input logic          wen,
  input logic          ld,
  input logic          ren,
  input logic          full_i,
  input logic          empty_i,
  input logic          half_i,
  input logic [PW-1:0] wgray,
  input logic [PW-1:0] rgray
);
  // R3: a write offered while full leaves the write pointer where it was
  assert_no_overflow_R3: assert property (@(posedge wclk) disable iff (rst)
    (wen && !ld && full_i) |=> $stable(wgray));

  // R4: a read request against an empty store leaves the read pointer alone
  assert_no_underflow_R4: assert property (@(posedge rclk) disable iff (rst)
    (ren && empty_i) |=> $stable(rgray));

  // R11: the Gray-coded pointers never change in more than one bit per edge
  assert_wgray_step_R11: assert property (@(posedge wclk) disable iff (rst)
    $onehot0(wgray ^ $past(wgray)));

  assert_rgray_step_R11: assert property (@(posedge rclk) disable iff (rst)
    $onehot0(rgray ^ $past(rgray)));

  // R7: a full store is always reported as more than half in use
  assert_full_is_half_R7: assert property (@(posedge wclk) disable iff (rst)
    full_i |-> half_i);
endmodule

bind dual_clock_fifo dcf_chk #(.PW(PW)) u_chk (
  .wclk(wclk), .rclk(rclk), .rst(rst), .wen(wen), .ld(ld), .ren(ren),
  .full_i(full_w), .empty_i(mem_empty_r), .half_i(half_full),
  .wgray(wgray_w), .rgray(rgray_r)
);

// File: tb/tb_dual_clock_fifo.sv
module tb_dual_clock_fifo;
  localparam int DEPTH = 256;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd_mode = 1'b0, wen = 1'b0, ld = 1'b0, ren = 1'b0, oe = 1'b1;
  logic [17:0] wdata = '0;
  logic [17:0] rdata;
  logic        rdata_drv, full_ir, empty_or, half_full, almost_full, almost_empty;

  int total = 0, fails = 0, nwr = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  dual_clock_fifo #(.DEPTH(DEPTH), .FLAG_STAGES(1), .ALMOST_REG(1'b1)) dut (
    .wclk(clk), .rst(rst), .rd_mode(rd_mode), .wen(wen), .ld(ld), .wdata(wdata),
    .rclk(clk), .ren(ren), .oe(oe), .rdata(rdata), .rdata_drv(rdata_drv),
    .full_ir(full_ir), .empty_or(empty_or), .half_full(half_full),
    .almost_full(almost_full), .almost_empty(almost_empty)
  );

  // stimulus word and the word expected back, in order
  localparam logic [35:0] VEC [8] = '{
    {18'h00001, 18'h00001}, {18'h3FFFF, 18'h3FFFF}, {18'h2AAAA, 18'h2AAAA},
    {18'h15555, 18'h15555}, {18'h00000, 18'h00000}, {18'h20000, 18'h20000},
    {18'h0F0F0, 18'h0F0F0}, {18'h12345, 18'h12345}
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic m);
    rst = 1'b1; rd_mode = m; wen = 0; ren = 0; ld = 0; oe = 1;
    repeat (3) tick();
    rst = 1'b0;
    nwr = 0;
  endtask

  task automatic wr(input logic [17:0] d);
    wen = 1'b1; wdata = d;
    tick();
    wen = 1'b0;
    nwr++;
  endtask

  task automatic rd();
    ren = 1'b1;
    tick();
    ren = 1'b0;
  endtask

  task automatic fill_to(input int target);
    while (nwr < target) wr(18'(nwr + 5));
    repeat (4) tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++; total++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    do_reset(1'b0);
    check("R1 empty", empty_or, 1);
    check("R1 full", full_ir, 0);
    check("R1 half", half_full, 0);
    check("R1 almost_empty", almost_empty, 1);
    check("R1 almost_full", almost_full, 0);

    // R5 crossing latency, R2 read data, R4 read on empty
    wr(18'h1ABCD);
    tick();
    check("R5 empty one edge after write", empty_or, 1);
    tick();
    check("R5 empty clears on second edge", empty_or, 0);
    rd();
    check("R2 first word", rdata, 18'h1ABCD);
    check("R4 empty after last read", empty_or, 1);
    rd();
    check("R4 rdata held on empty read", rdata, 18'h1ABCD);
    wr(18'h00777);
    repeat (3) tick();
    rd();
    check("R4 pointer unmoved", rdata, 18'h00777);

    // R2 table of vectors
    for (int i = 0; i < 8; i++) wr(VEC[i][35:18]);
    repeat (4) tick();
    for (int i = 0; i < 8; i++) begin
      rd();
      check("R2 table order", rdata, VEC[i][17:0]);
    end

    // R10 output enable
    oe = 1'b0;
    #1;
    check("R10 rdata zero", rdata, 0);
    check("R10 drv low", rdata_drv, 0);
    oe = 1'b1;
    #1;
    check("R10 drv high", rdata_drv, 1);
    check("R10 rdata returns", rdata, VEC[7][17:0]);

    // R8 default thresholds, R7 half, R3 full
    do_reset(1'b0);
    fill_to(63);  check("R8 almost_empty at 63", almost_empty, 1);
    fill_to(64);  check("R8 almost_empty at 64", almost_empty, 0);
    fill_to(128); check("R7 half at 128", half_full, 0);
    fill_to(129); check("R7 half at 129", half_full, 1);
    fill_to(192); check("R8 almost_full at 192", almost_full, 0);
    fill_to(193); check("R8 almost_full at 193", almost_full, 1);
    fill_to(255); check("R3 full at 255", full_ir, 0);
    fill_to(256); check("R3 full at 256", full_ir, 1);
    wr(18'h3FFFF);
    repeat (2) tick();
    begin
      int bad = 0;
      for (int i = 0; i < DEPTH; i++) begin
        rd();
        if (rdata !== 18'(i + 5)) bad++;
      end
      check("R3 stored words intact", bad, 0);
    end
    check("R3 dropped write not stored", empty_or, 1);

    // R9 offset load: near-empty then near-full
    do_reset(1'b0);
    ld = 1'b1; wen = 1'b1; wdata = 18'd4; tick();
    wdata = 18'd10; tick();
    ld = 1'b0; wen = 1'b0;
    repeat (4) tick();
    check("R9 load stores no data", empty_or, 1);
    fill_to(4);   check("R9 almost_empty at 4", almost_empty, 1);
    fill_to(5);   check("R9 almost_empty at 5", almost_empty, 0);
    fill_to(245); check("R9 almost_full at 245", almost_full, 0);
    fill_to(246); check("R9 almost_full at 246", almost_full, 1);

    // R6 fall-through mode
    do_reset(1'b1);
    check("R6 input ready", full_ir, 1);
    check("R6 not output ready", empty_or, 0);
    wr(18'h0C0DE);
    repeat (4) tick();
    check("R6 output ready", empty_or, 1);
    check("R6 word falls through", rdata, 18'h0C0DE);
    wr(18'h0BEEF);
    repeat (4) tick();
    rd();
    check("R6 next word", rdata, 18'h0BEEF);
    check("R6 still ready", empty_or, 1);
    rd();
    check("R6 ready drops", empty_or, 0);

    // R12 mode captured only during reset
    do_reset(1'b0);
    rd_mode = 1'b1;
    wr(18'h05A5A);
    repeat (4) tick();
    rd();
    check("R12 standard data", rdata, 18'h05A5A);
    check("R12 standard empty meaning", empty_or, 1);

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule